// File: doc/BRIEF.md
# Serial Command Slave with Status Readback

This block is the serial front end of a four-channel load-switch controller. A host drives a clock, a low-active select and a data line. While select is low, the block takes in 16-bit command words and returns a 16-bit status word on its serial output. The three serial inputs are oversampled in the block's own clock domain through a synchronizer. All decisions are made on clean internal edge strobes.

A four-state machine sequences each transaction. ST_IDLE waits with the output disabled. On a falling select edge (IDLE->FRAME) it loads the status word into the shift register and enables the output. ST_FRAME shifts one bit for each rising serial-clock edge and counts the edges. On a rising select edge, a frame whose edge count is a non-zero multiple of 16 moves to ST_COMMIT (FRAME->COMMIT), and any other frame moves to ST_DROP (FRAME->DROP). ST_COMMIT writes the last 16 received bits into the addressed register. ST_DROP changes nothing. Both return to ST_IDLE after one cycle (COMMIT->IDLE, DROP->IDLE). The status word is built from the last accepted command: its watchdog bit, its address field, a normal-mode flag, and a 9-bit payload. The payload comes from the register named by a persistent status selector.

Per-channel fault flags are sticky. They gather fault input only while no frame is in progress, and a selector write can clear them.

Top module: `spi_status_slave`

## Requirements
- R1: A frame is accepted only if the number of rising serial-clock edges while select is low is a non-zero multiple of 16. Only an accepted frame changes any register or output.
- R2: The status word leaves on `spi_so` MSB first, starting with bit 15. `spi_si` is sampled on each rising serial-clock edge.
- R3: For a frame longer than 16 bits, the output bits after the first 16 repeat the input bits of the same frame, 16 edges later.
- R4: The accepted command is the last 16 bits received, and it takes effect after select rises.
- R5: While select is high, `spi_so_oe` and `spi_so` are 0. `spi_so_oe` is 1 throughout a frame.
- R6: A rejected frame leaves the registers, the watchdog bit, the echoed address and the selector exactly as they were.
- R7: Status bit 15 is the watchdog bit (bit 15) of the last accepted command. Status bits 14:10 are that command's address field (bits 14:10).
- R8: Status bit 9 equals `mode_normal` at the start of the frame.
- R9: Status bits 8:0 are the payload chosen by the selector. The selector keeps its value until the next selector write.
- R10: In the selector, bits 4:3 are the channel and bits 2:0 the kind. Kind 0 returns the fault flags, 1 returns conf0, 2 conf1, 3 ocr, 4 pwm, 5 the global config, 6 the selector itself (zero-extended) and 7 the calibration trim. Kinds 5 and 7 ignore the channel. A write of kind 6 is ignored.
- R11: Fault flags OR in `fault_in` only while select is high and no commit is pending, and hold still during a frame. A selector write with bit 9 set clears the flags of the channel named by its new selector value.
- R12: After reset, all registers, `wd_last`, `spi_so` and `spi_so_oe` are 0.
- R13: Command layout: bit 15 is the watchdog, bits 14:13 the channel, bits 12:10 the kind, bit 9 the fault-clear flag and bits 8:0 the data. A write of kinds 1 to 5 or 7 stores data[8:0]. A write of kind 0 stores data[4:0] as the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Low-active frame select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out, 0 when disabled |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| mode_normal | input | 1 | Normal-mode indication reported in status bit 9 |
| fault_in | input | 36 | Per-channel fault inputs, 9 bits per channel |
| ch_conf0 | output | 36 | Per-channel configuration word 0 |
| ch_conf1 | output | 36 | Per-channel configuration word 1 |
| ch_ocr | output | 36 | Per-channel overcurrent setting |
| ch_pwm | output | 36 | Per-channel PWM setting |
| glb_cfg | output | 9 | Global configuration |
| cal_trim | output | 9 | Calibration trim |
| wd_last | output | 1 | Watchdog bit of the last accepted command |

## Verification
A change on a serial pin acts at the third clock edge after it: two edges through the synchronizer and one through the edge register. So shifted output is valid three cycles after a serial-clock rise, and a commit lands four cycles after select rises. The bench holds each serial-clock phase for four cycles and reads `spi_so` at the end of the low phase, just before the next rise. It checks registers and status ten cycles after select rises. The sweep covers every channel and kind, and frame lengths 0 to 48 edges. Expected status words, daisy-chained bits and register contents are computed from a model of the requirements.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int CMD_W   = 16;
    localparam int REG_W   = 9;
    localparam int CH_W    = 2;
    localparam int NCH     = 1 << CH_W;
    localparam int KIND_W  = 3;
    localparam int ADDR_W  = CH_W + KIND_W;
    localparam int SEL_W   = ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_COMMIT,
        ST_DROP
    } fsm_t;

    typedef enum logic [KIND_W-1:0] {
        K_SELECT = 3'd0,
        K_CONF0  = 3'd1,
        K_CONF1  = 3'd2,
        K_OCR    = 3'd3,
        K_PWM    = 3'd4,
        K_GLOBAL = 3'd5,
        K_ECHO   = 3'd6,
        K_CAL    = 3'd7
    } kind_t;

    // Command word: the order of these fields is decoded by the register bank.
    typedef struct packed {
        logic             wd;
        logic [CH_W-1:0]  ch;
        kind_t            kind;
        logic             clr;
        logic [REG_W-1:0] data;
    } cmd_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int            N       = 3,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= {STAGES{RST_VAL[i]}};
            end else begin
                pipe <= {pipe[STAGES-2:0], din[i]};
            end
        end

        assign level[i] = pipe[STAGES-1];
    end

endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
    parameter int W  = 16,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         si_bit,
    output logic [W-1:0] word,
    output logic         len_ok
);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          seen_q;

    // The count wraps at W, so only the remainder and a seen-edge flag are kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            sh_q   <= load_word;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (shift) begin
            sh_q   <= {sh_q[W-2:0], si_bit};
            cnt_q  <= cnt_q + 1'b1;
            seen_q <= 1'b1;
        end
    end

    assign word   = sh_q;
    assign len_ok = seen_q && (cnt_q == '0);

endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [CMD_W-1:0]     cmd,
    input  logic                 track_fault,
    input  logic [NCH*REG_W-1:0] fault_in,
    input  logic                 mode_normal,
    output logic [CMD_W-1:0]     status_word,
    output logic [NCH*REG_W-1:0] ch_conf0,
    output logic [NCH*REG_W-1:0] ch_conf1,
    output logic [NCH*REG_W-1:0] ch_ocr,
    output logic [NCH*REG_W-1:0] ch_pwm,
    output logic [REG_W-1:0]     glb_cfg,
    output logic [REG_W-1:0]     cal_trim,
    output logic                 wd_last
);

    cmd_t               c;
    logic [SEL_W-1:0]   sel_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [NCH*REG_W-1:0] fault_q;
    logic [REG_W-1:0]   payload;
    logic [CH_W-1:0]    rd_ch;
    logic [CH_W-1:0]    clr_ch;

    assign c      = cmd_t'(cmd);
    assign rd_ch  = sel_q[SEL_W-1:KIND_W];
    assign clr_ch = c.data[SEL_W-1:KIND_W];

    // Per-channel storage
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [REG_W-1:0] conf0_q, conf1_q, ocr_q, pwm_q, flt_q;
        logic             hit;

        assign hit = commit && (c.ch == CH_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                conf0_q <= '0;
                conf1_q <= '0;
                ocr_q   <= '0;
                pwm_q   <= '0;
            end else if (hit) begin
                unique case (c.kind)
                    K_CONF0: conf0_q <= c.data;
                    K_CONF1: conf1_q <= c.data;
                    K_OCR:   ocr_q   <= c.data;
                    K_PWM:   pwm_q   <= c.data;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flt_q <= '0;
            end else if (commit && c.kind == K_SELECT && c.clr && clr_ch == CH_W'(i)) begin
                flt_q <= '0;
            end else if (track_fault) begin
                flt_q <= flt_q | fault_in[i*REG_W +: REG_W];
            end
        end

        assign ch_conf0[i*REG_W +: REG_W] = conf0_q;
        assign ch_conf1[i*REG_W +: REG_W] = conf1_q;
        assign ch_ocr[i*REG_W +: REG_W]   = ocr_q;
        assign ch_pwm[i*REG_W +: REG_W]   = pwm_q;
        assign fault_q[i*REG_W +: REG_W]  = flt_q;
    end

    // Global storage and the record of the last accepted command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            addr_q   <= '0;
            wd_last  <= 1'b0;
            glb_cfg  <= '0;
            cal_trim <= '0;
        end else if (commit) begin
            wd_last <= c.wd;
            addr_q  <= {c.ch, c.kind};
            unique case (c.kind)
                K_SELECT: sel_q    <= c.data[SEL_W-1:0];
                K_GLOBAL: glb_cfg  <= c.data;
                K_CAL:    cal_trim <= c.data;
                default: ;
            endcase
        end
    end

    // Readback multiplexer
    always_comb begin
        unique case (kind_t'(sel_q[KIND_W-1:0]))
            K_SELECT: payload = fault_q[int'(rd_ch)*REG_W +: REG_W];
            K_CONF0:  payload = ch_conf0[int'(rd_ch)*REG_W +: REG_W];
            K_CONF1:  payload = ch_conf1[int'(rd_ch)*REG_W +: REG_W];
            K_OCR:    payload = ch_ocr[int'(rd_ch)*REG_W +: REG_W];
            K_PWM:    payload = ch_pwm[int'(rd_ch)*REG_W +: REG_W];
            K_GLOBAL: payload = glb_cfg;
            K_ECHO:   payload = REG_W'(sel_q);
            K_CAL:    payload = cal_trim;
        endcase
    end

    assign status_word = {wd_last, addr_q, mode_normal, payload};

endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_si,
    output logic                 spi_so,
    output logic                 spi_so_oe,
    input  logic                 mode_normal,
    input  logic [NCH*REG_W-1:0] fault_in,
    output logic [NCH*REG_W-1:0] ch_conf0,
    output logic [NCH*REG_W-1:0] ch_conf1,
    output logic [NCH*REG_W-1:0] ch_ocr,
    output logic [NCH*REG_W-1:0] ch_pwm,
    output logic [REG_W-1:0]     glb_cfg,
    output logic [REG_W-1:0]     cal_trim,
    output logic                 wd_last
);

    fsm_t             state_q, state_d;
    logic [2:0]       lvl;
    logic             sclk_prev, cs_prev;
    logic             sclk_rise, cs_fall, cs_rise;
    logic             load, shift, commit, track_fault;
    logic [CMD_W-1:0] status_word, frame_word;
    logic             len_ok;
    logic             so_oe_q;

    spi_in_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_si, spi_cs_n, spi_sclk}),
        .level (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= lvl[0];
            cs_prev   <= lvl[1];
        end
    end

    assign sclk_rise = lvl[0] && !sclk_prev;
    assign cs_fall   = !lvl[1] && cs_prev;
    assign cs_rise   = lvl[1] && !cs_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_FRAME;
            ST_FRAME:  if (cs_rise) state_d = len_ok ? ST_COMMIT : ST_DROP;
            ST_COMMIT: state_d = ST_IDLE;
            ST_DROP:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) so_oe_q <= 1'b0;
        else        so_oe_q <= (state_d == ST_FRAME);
    end

    assign load        = (state_q == ST_IDLE) && cs_fall;
    assign shift       = (state_q == ST_FRAME) && sclk_rise;
    assign commit      = (state_q == ST_COMMIT);
    assign track_fault = (state_q == ST_IDLE);
    assign spi_so_oe   = so_oe_q;
    assign spi_so      = so_oe_q && frame_word[CMD_W-1];

    spi_frame_shift #(
        .W (CMD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (status_word),
        .shift     (shift),
        .si_bit    (lvl[2]),
        .word      (frame_word),
        .len_ok    (len_ok)
    );

    spi_ctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .cmd         (frame_word),
        .track_fault (track_fault),
        .fault_in    (fault_in),
        .mode_normal (mode_normal),
        .status_word (status_word),
        .ch_conf0    (ch_conf0),
        .ch_conf1    (ch_conf1),
        .ch_ocr      (ch_ocr),
        .ch_pwm      (ch_pwm),
        .glb_cfg     (glb_cfg),
        .cal_trim    (cal_trim),
        .wd_last     (wd_last)
    );

endmodule

// File: rtl/spi_status_slave_chk.sv
module spi_status_slave_chk
    import spi_stat_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input fsm_t                     state,
    input logic                     so,
    input logic                     so_oe,
    input logic                     len_ok,
    input logic [CMD_W-1:0]         cmd_word,
    input logic                     wd_last,
    input logic [4*NCH*REG_W+2*REG_W-1:0] cfg_bus,
    input logic [NCH*REG_W-1:0]     fault_q
);

    // R5
    so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so);

    // R5
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state == ST_FRAME));

    // R1
    commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> len_ok);

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(cfg_bus));

    // R6
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |=> ($stable(cfg_bus) && $stable(wd_last)));

    // R7
    wd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (wd_last == $past(cmd_word[CMD_W-1])));

    // R11
    fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME) |=> $stable(fault_q));

endmodule

bind spi_status_slave spi_status_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .so       (spi_so),
    .so_oe    (spi_so_oe),
    .len_ok   (len_ok),
    .cmd_word (frame_word),
    .wd_last  (wd_last),
    .cfg_bus  ({ch_conf0, ch_conf1, ch_ocr, ch_pwm, glb_cfg, cal_trim}),
    .fault_q  (u_regs.fault_q)
);

// File: tb/sim_spi_status_slave.sv
`timescale 1ns/100ps
module sim_spi_status_slave;
    import spi_stat_pkg::*;

    localparam int HALF = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n, spi_sclk, spi_cs_n, spi_si, spi_so, spi_so_oe;
    logic                 mode_normal, wd_last;
    logic [NCH*REG_W-1:0] fault_in, ch_conf0, ch_conf1, ch_ocr, ch_pwm;
    logic [REG_W-1:0]     glb_cfg, cal_trim;

    spi_status_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .mode_normal(mode_normal), .fault_in(fault_in),
        .ch_conf0(ch_conf0), .ch_conf1(ch_conf1), .ch_ocr(ch_ocr), .ch_pwm(ch_pwm),
        .glb_cfg(glb_cfg), .cal_trim(cal_trim), .wd_last(wd_last)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [REG_W-1:0] m_conf0 [NCH];
    logic [REG_W-1:0] m_conf1 [NCH];
    logic [REG_W-1:0] m_ocr   [NCH];
    logic [REG_W-1:0] m_pwm   [NCH];
    logic [REG_W-1:0] m_fault [NCH];
    logic [REG_W-1:0] m_gcfg, m_cal;
    logic [4:0]       m_sel, m_addr;
    logic             m_wd;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic wd, input int ch, input int kind,
                                       input logic clr, input logic [8:0] d);
        return {wd, 2'(ch), 3'(kind), clr, d};
    endfunction

    function automatic logic [15:0] exp_status();
        logic [8:0] p;
        int ch;
        ch = int'(m_sel[4:3]);
        case (m_sel[2:0])
            3'd0: p = m_fault[ch];
            3'd1: p = m_conf0[ch];
            3'd2: p = m_conf1[ch];
            3'd3: p = m_ocr[ch];
            3'd4: p = m_pwm[ch];
            3'd5: p = m_gcfg;
            3'd6: p = {4'b0, m_sel};
            default: p = m_cal;
        endcase
        return {m_wd, m_addr, mode_normal, p};
    endfunction

    task automatic model_commit(input logic [15:0] w);
        int ch;
        ch = int'(w[14:13]);
        m_wd   = w[15];
        m_addr = w[14:10];
        case (w[12:10])
            3'd0: begin
                m_sel = w[4:0];
                if (w[9]) m_fault[int'(w[4:3])] = '0;
            end
            3'd1: m_conf0[ch] = w[8:0];
            3'd2: m_conf1[ch] = w[8:0];
            3'd3: m_ocr[ch]   = w[8:0];
            3'd4: m_pwm[ch]   = w[8:0];
            3'd5: m_gcfg      = w[8:0];
            3'd7: m_cal       = w[8:0];
            default: ;
        endcase
    endtask

    task automatic check_regs(input string req);
        logic [NCH*REG_W-1:0] e0, e1, eo, ep;
        for (int i = 0; i < NCH; i++) begin
            e0[i*REG_W +: REG_W] = m_conf0[i];
            e1[i*REG_W +: REG_W] = m_conf1[i];
            eo[i*REG_W +: REG_W] = m_ocr[i];
            ep[i*REG_W +: REG_W] = m_pwm[i];
        end
        check({req, " conf0"}, 64'(ch_conf0), 64'(e0));
        check({req, " conf1"}, 64'(ch_conf1), 64'(e1));
        check({req, " ocr"},   64'(ch_ocr),   64'(eo));
        check({req, " pwm"},   64'(ch_pwm),   64'(ep));
        check({req, " glb"},   64'({glb_cfg, cal_trim, wd_last}), 64'({m_gcfg, m_cal, m_wd}));
    endtask

    // One frame of L serial-clock edges; tx[L-1] is sent first.
    task automatic frame(input int L, input logic [63:0] tx, input string req,
                         input bit mid_fault, input int fch, input logic [8:0] fpat);
        logic [63:0] rx, mask;
        logic [15:0] es;
        rx = '0;
        es = exp_status();
        spi_cs_n = 1'b0;
        wait_clk(6);
        for (int i = L - 1; i >= 0; i--) begin
            spi_si = tx[i];
            if (mid_fault && i == L - 4) fault_in[fch*REG_W +: REG_W] = fpat;
            if (mid_fault && i == L - 8) fault_in[fch*REG_W +: REG_W] = '0;
            wait_clk(HALF);
            rx = {rx[62:0], spi_so};
            if (i == L - 1) check("R5 oe in frame", 64'(spi_so_oe), 64'd1);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(10);
        if (L >= 16) begin
            // R2 R7 R8 R9: status word comes out first, MSB first
            check({req, " R2 status"}, (rx >> (L - 16)) & 64'hFFFF, 64'(es));
        end else if (L > 0) begin
            mask = (64'd1 << L) - 1;
            check({req, " R2 partial"}, rx & mask, 64'(es >> (16 - L)));
        end
        if (L > 16) begin
            mask = (64'd1 << (L - 16)) - 1;
            check({req, " R3 chain"}, rx & mask, (tx >> 16) & mask);
        end
        if (L > 0 && L % 16 == 0) model_commit(tx[15:0]);
        check_regs(req);
        check("R5 idle so", 64'({spi_so_oe, spi_so}), 64'd0);
    endtask

    task automatic idle_fault(input int ch, input logic [8:0] pat);
        fault_in[ch*REG_W +: REG_W] = pat;
        wait_clk(6);
        fault_in[ch*REG_W +: REG_W] = '0;
        wait_clk(6);
        m_fault[ch] = m_fault[ch] | pat;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_si = 1'b0;
        mode_normal = 1'b1; fault_in = '0;
        for (int i = 0; i < NCH; i++) begin
            m_conf0[i] = '0; m_conf1[i] = '0; m_ocr[i] = '0; m_pwm[i] = '0; m_fault[i] = '0;
        end
        m_gcfg = '0; m_cal = '0; m_sel = '0; m_addr = '0; m_wd = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R12
        check_regs("R12 reset");
        check("R12 so", 64'({spi_so_oe, spi_so}), 64'd0);

        // R13: write every per-channel register of every channel
        for (int ch = 0; ch < NCH; ch++)
            for (int k = 1; k <= 4; k++)
                frame(16, 64'(mk(1'(ch + k), ch, k, 1'b0, 9'(ch * 71 + k * 29 + 5))), "R13", 0, 0, '0);

        // R10 R9: select each channel and kind, then read it back
        frame(16, 64'(mk(0, 0, 5, 0, 9'h1C3)), "R10 glb", 0, 0, '0);
        frame(16, 64'(mk(1, 0, 7, 0, 9'h0B6)), "R10 cal", 0, 0, '0);
        for (int ch = 0; ch < NCH; ch++)
            for (int k = 0; k < 8; k++) begin
                frame(16, 64'(mk(1'(k), ch, 0, 0, 9'({ch[1:0], k[2:0]}))), "R10 sel", 0, 0, '0);
                frame(16, 64'(mk(0, ch, 6, 0, 9'h1FF)), "R10 ignored write", 0, 0, '0);
            end
        // R10: globals ignore the channel field
        frame(16, 64'(mk(0, 3, 7, 0, 9'h155)), "R10 cal ch3", 0, 0, '0);
        frame(16, 64'(mk(1, 2, 5, 0, 9'h02A)), "R10 glb ch2", 0, 0, '0);

        // R9: selector persists across other writes
        frame(16, 64'(mk(0, 0, 0, 0, 9'({2'd2, 3'd2}))), "R9 sel", 0, 0, '0);
        for (int n = 0; n < 3; n++)
            frame(16, 64'(mk(1'(n), 2, 2, 0, 9'(n * 97 + 3))), "R9 persist", 0, 0, '0);

        // R8
        mode_normal = 1'b0;
        frame(16, 64'(mk(0, 1, 3, 0, 9'h111)), "R8 mode0", 0, 0, '0);
        mode_normal = 1'b1;
        frame(16, 64'(mk(0, 1, 3, 0, 9'h122)), "R8 mode1", 0, 0, '0);

        // R1 R4 R6 R3: frame length sweep
        for (int L = 0; L <= 48; L++) begin
            logic [63:0] tx;
            tx = {mk(1, 3, 1, 0, 9'h1AA), mk(0, L % 4, 2, 0, 9'(L * 13)),
                  mk(1, L % 4, 3, 0, 9'(L * 7 + 1)), mk(1'(L), L % 4, 4, 0, 9'(L * 37 + 3))};
            frame(L, tx, "R1 R4 R6 len", 0, 0, '0);
        end

        // R11: sticky faults, frozen during a frame, cleared by a selector write
        idle_fault(1, 9'h155);
        frame(16, 64'(mk(0, 0, 0, 0, 9'({2'd1, 3'd0}))), "R11 sel fault", 0, 0, '0);
        frame(16, 64'(mk(0, 0, 6, 0, 9'h0)), "R11 frozen", 1, 1, 9'h0AA);
        frame(16, 64'(mk(0, 0, 6, 0, 9'h0)), "R11 read", 0, 0, '0);
        frame(16, 64'(mk(0, 0, 0, 1, 9'({2'd1, 3'd0}))), "R11 clear", 0, 0, '0);
        frame(16, 64'(mk(0, 0, 6, 0, 9'h0)), "R11 cleared", 0, 0, '0);
        idle_fault(1, 9'h0AA);
        idle_fault(2, 9'h101);
        frame(16, 64'(mk(1, 0, 6, 0, 9'h0)), "R11 idle capture", 0, 0, '0);
        frame(16, 64'(mk(0, 0, 0, 0, 9'({2'd2, 3'd0}))), "R11 sel ch2", 0, 0, '0);
        frame(16, 64'(mk(0, 0, 6, 0, 9'h0)), "R11 ch2", 0, 0, '0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule